// File: doc/BRIEF.md
# Dual-Pixel Row Readout Window Generator

This block produces the per-row valid window for a sensor readout path that moves two pixels on every clock. The row sequencer pulses a row-start strobe when it begins reading out a row. On that strobe the block loads a programmed pair count, clears its pair index and opens the valid window. The index then advances by one on each clock. The window closes in the cycle after the index has matched the loaded count.

The count is programmed as half the region-of-interest width, minus one. This makes the window exactly count+1 clocks long, which is enough clocks to read every pixel pair of the row. A one-clock end-of-row pulse marks the cycle in which the window closes. A new row-start strobe that arrives while a row is still open cuts that row short and starts the new row from index zero.

Top module: `pair_window_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pix_valid`, `pair_idx` and `row_end` are all 0.
- R2: When `row_start` is sampled high on a rising clock edge, the cycle after that edge has `pix_valid` = 1 and `pair_idx` = 0.
- R3: While the window is open and no `row_start` is sampled, `pair_idx` rises by exactly one per clock.
- R4: With a loaded count N, `pix_valid` stays high for exactly N+1 consecutive cycles, and `pair_idx` = N in the last of them.
- R5: `row_end` is high for exactly one cycle: the first cycle with `pix_valid` low after a window that ran to its full length. It is never high together with `pix_valid`.
- R6: A `row_start` sampled while the window is open, including in its last cycle, restarts the window at `pair_idx` = 0 using the newly presented count, and no `row_end` pulse is produced.
- R7: `pair_count` is sampled only on the edge that samples `row_start`. Changes to it at any other time have no effect on the current window.
- R8: A loaded count of 0 gives a window of a single cycle at `pair_idx` = 0, followed by `row_end`.
- R9: The full 12-bit count 4095 gives a window of 4096 cycles, with no wrap of `pair_idx`.
- R10: Whenever `pix_valid` is low, `pair_idx` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | One-clock strobe that opens (or restarts) the row window |
| pair_count | input | 12 | Index of the last pixel pair in the row: (ROI width / 2) - 1 |
| pix_valid | output | 1 | High while pixel pairs of the row are being delivered |
| pair_idx | output | 12 | Index of the pixel pair in the current cycle |
| row_end | output | 1 | One-clock pulse in the cycle the window closes |

## Verification
The hardest case to reach from the ports is a new row-start that lands exactly in the last cycle of a window. In that cycle the close and the restart compete, and the restart must win without an end-of-row pulse. The stimulus opens a row, counts its clocks, and raises the strobe in the clock where the index equals the count. It also raises the strobe mid-row, and it rewrites the count input on every clock inside the window to show that only the value sampled at the strobe matters. A row with the maximum count walks the index across its full 12-bit range.

// File: rtl/pair_window_pkg.sv
package pair_window_pkg;

    localparam int unsigned PW_DEFAULT_CNT_W = 12;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

endpackage

// File: rtl/pair_window_limit.sv
module pair_window_limit #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] limit
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
    } limit_reg_t;

    limit_reg_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (load) begin
            lim_d.limit = count_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else begin
            lim_q <= lim_d;
        end
    end

    assign limit = lim_q.limit;

endmodule

// File: rtl/pair_window_seq.sv
module pair_window_seq
    import pair_window_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    output logic             open,
    output logic [CNT_W-1:0] idx,
    output logic             closed
);

    localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);

    typedef struct packed {
        win_state_e       state;
        logic [CNT_W-1:0] idx;
        logic             closed;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     at_last;

    assign at_last = (seq_q.idx == limit);

    always_comb begin
        seq_d        = seq_q;
        seq_d.closed = 1'b0;
        if (start) begin
            seq_d.state = WIN_OPEN;
            seq_d.idx   = '0;
        end else if (seq_q.state == WIN_OPEN) begin
            if (at_last) begin
                seq_d.state  = WIN_IDLE;
                seq_d.idx    = '0;
                seq_d.closed = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + IDX_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: WIN_IDLE, idx: '0, closed: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign open   = (seq_q.state == WIN_OPEN);
    assign idx    = seq_q.idx;
    assign closed = seq_q.closed;

endmodule

// File: rtl/pair_window_gen.sv
module pair_window_gen
    import pair_window_pkg::*;
#(
    parameter int unsigned CNT_W = PW_DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_start,
    input  logic [CNT_W-1:0] pair_count,
    output logic             pix_valid,
    output logic [CNT_W-1:0] pair_idx,
    output logic             row_end
);

    logic [CNT_W-1:0] win_limit;

    pair_window_limit #(
        .CNT_W (CNT_W)
    ) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (row_start),
        .count_in (pair_count),
        .limit    (win_limit)
    );

    pair_window_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (row_start),
        .limit  (win_limit),
        .open   (pix_valid),
        .idx    (pair_idx),
        .closed (row_end)
    );

endmodule

// File: rtl/pair_window_gen_chk.sv
module pair_window_gen_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_start,
    input logic             pix_valid,
    input logic [CNT_W-1:0] pair_idx,
    input logic             row_end,
    input logic [CNT_W-1:0] win_limit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_sync_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (pix_valid && pair_idx == '0));

    assert_rise_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(row_start));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !row_start && pair_idx != win_limit)
        |=> (pix_valid && pair_idx == $past(pair_idx) + ONE));

    assert_close_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !row_start && pair_idx == win_limit) |=> (!pix_valid && row_end));

    assert_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |=> !row_end);

    assert_end_excl_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |-> !pix_valid);

    assert_restart_no_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> !row_end);

    assert_limit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !row_start |=> $stable(win_limit));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pair_idx == '0));

endmodule

bind pair_window_gen pair_window_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_start (row_start),
    .pix_valid (pix_valid),
    .pair_idx  (pair_idx),
    .row_end   (row_end),
    .win_limit (win_limit)
);

// File: tb/pair_window_gen_test.sv
module pair_window_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;

    typedef struct {
        logic             v;
        logic [CNT_W-1:0] i;
        logic             e;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             row_start = 1'b0;
    logic [CNT_W-1:0] pair_count = '0;
    logic             pix_valid;
    logic [CNT_W-1:0] pair_idx;
    logic             row_end;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 1'b0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_window_gen #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_start  (row_start),
        .pair_count (pair_count),
        .pix_valid  (pix_valid),
        .pair_idx   (pair_idx),
        .row_end    (row_end)
    );

    task automatic check_now(string tag, logic ev, logic [CNT_W-1:0] ei, logic ee);
        n_checks++;
        if (pix_valid !== ev || pair_idx !== ei || row_end !== ee) begin
            n_fail++;
            $display("FAIL %s: got valid=%b idx=%0d end=%b, expected valid=%b idx=%0d end=%b",
                     tag, pix_valid, pair_idx, row_end, ev, ei, ee);
        end
    endtask

    // driver: one clock of stimulus plus the outputs expected after the next edge
    task automatic cyc(logic s, logic [CNT_W-1:0] c, logic ev, logic [CNT_W-1:0] ei,
                       logic ee, string tag);
        exp_t x;
        @(negedge clk);
        row_start  = s;
        pair_count = c;
        x.v = ev; x.i = ei; x.e = ee; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // opens a row with count n; stops after index 'stop' without a close if stop < n
    task automatic row(int n, int stop, string first_tag, bit close);
        cyc(1'b1, CNT_W'(n), 1'b1, '0, 1'b0, first_tag);
        for (int k = 1; k <= stop; k++) begin
            // count input scrambled inside the row (R7)
            cyc(1'b0, ~CNT_W'(n + k), 1'b1, CNT_W'(k), 1'b0,
                (k == n) ? "R4" : "R3/R7");
        end
        if (close) cyc(1'b0, CNT_W'(7), 1'b0, '0, 1'b1, (n == 0) ? "R8" : "R5");
    endtask

    task automatic idle(int k);
        for (int j = 0; j < k; j++) cyc(1'b0, CNT_W'(j * 3 + 1), 1'b0, '0, 1'b0, "R10");
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                check_now(x.tag, x.v, x.i, x.e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        pair_count = 12'hFFF;
        row_start  = 1'b1;
        repeat (3) @(negedge clk);
        check_now("R1", 1'b0, '0, 1'b0);
        row_start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_now("R1", 1'b0, '0, 1'b0);
        mon_on = 1'b1;

        idle(2);
        row(3, 3, "R2", 1'b1);             // basic row, R2 R3 R4 R5
        idle(3);
        row(0, 0, "R8", 1'b1);             // single-cycle window
        idle(1);
        row(5, 5, "R2", 1'b1);             // scrambled count during row
        row(2, 2, "R7", 1'b1);             // next row uses newly sampled count
        idle(2);
        row(6, 3, "R2", 1'b0);             // cut mid-row
        row(2, 2, "R6", 1'b1);             // restart from zero
        row(4, 4, "R2", 1'b0);             // strobe on the last cycle
        row(1, 1, "R6", 1'b1);
        idle(2);
        row(4095, 4095, "R9", 1'b1);       // full range
        idle(3);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule